// File: doc/BRIEF.md
# Six-Source Prioritised Interrupt Controller

This block collects interrupt requests for an 8-bit microcontroller core and turns them into a single request line and a 16-bit service address for the CPU. It has six sources:

- two external pins, each active low;
- overflow flags from two timers;
- a serial port, which requests on its receive flag or its transmit flag;
- a third timer, which requests on its overflow flag or its capture/reload flag.

An enable register gates each source on its own, and one global bit gates them all. A second register puts each source at one of two levels. When several requests are eligible at once, the block picks by level first and then by a fixed source order. Each service address is 8 bytes above the one before it.

The CPU takes a request by pulsing an acknowledge strobe. From then on the controller tracks which level is in service. A low-level routine can be interrupted by a high-level request. Nothing interrupts a high-level routine, and a low-level routine is never interrupted by another low-level request. A return strobe ends the innermost active routine.

Each external pin passes through a two-flop synchronizer and can be set to level or falling-transition sensing. A transition is latched until its request is acknowledged. All configuration goes through a small register port with combinational read-back.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After synchronous reset, every register reads back 0, nothing is in service, and `irq_req` is 0.
- R2: The register port has three registers. Address 0 is the enable register: bit 7 is the global gate, bit 0 enables external pin 0, bit 1 timer 0, bit 2 external pin 1, bit 3 timer 1, bit 4 the serial port, and bit 5 timer 2. Bit 6 ignores writes and reads 0. Address 1 is the level register: bit i (i = 0..5, same source order) set to 1 puts that source at high level, and bits 7:6 read 0. Address 2 is the sense register: bit 0 selects transition sensing for external pin 0 and bit 1 for pin 1, and bits 7:2 read 0.
- R3: While the global gate (bit 7 of address 0) is 0, `irq_req` stays 0 whatever the requests.
- R4: A source whose enable bit is 0 never causes `irq_req`.
- R5: Among eligible requests at the same level, the lowest source index wins. The order is: external 0, timer 0, external 1, timer 1, serial, timer 2. `irq_vec` is 0x0003 + 8 × index (0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B) while `irq_req` is 1, and 0 otherwise.
- R6: The serial source requests when `ser_rx` or `ser_tx` is 1. Timer 2 requests when `tmr2_ovf` or `tmr2_cap` is 1.
- R7: In level sensing (sense bit 0), an external source requests while its synchronized pin is low. The request shows on `irq_req` two clock edges after the pin falls and ends two edges after the pin rises. Nothing is latched.
- R8: In transition sensing (sense bit 1), a synchronized high-to-low change sets a flag. The flag stays set after the pin returns high and clears when its own vector is acknowledged.
- R9: An eligible high-level request wins over any low-level request, whatever their source order.
- R10: While a high-level routine is in service, `irq_req` is 0. While only a low-level routine is in service, only high-level requests are presented.
- R11: A return strobe clears the high in-service bit if it is set, and otherwise the low in-service bit.
- R12: An acknowledge taken while `irq_req` is 0 changes no in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 level, 2 sense |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ext_n | input | 2 | External interrupt pins, active low, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow request |
| tmr1_ovf | input | 1 | Timer 1 overflow request |
| ser_rx | input | 1 | Serial receive request flag |
| ser_tx | input | 1 | Serial transmit request flag |
| tmr2_ovf | input | 1 | Timer 2 overflow request |
| tmr2_cap | input | 1 | Timer 2 capture/reload request |
| irq_ack | input | 1 | CPU accepts the presented vector |
| irq_ret | input | 1 | CPU returns from the current routine |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 16 | Service address of the presented request |

## Verification
A wrong in-service bit shows on the next cycle as a request that is wrongly held back or wrongly presented. A stuck high bit silences `irq_req` entirely. A stuck low bit hides every low-level source. A corrupted enable or level bit shows at once, as a wrong vector or a missing request in the same cycle the sources are driven. A transition flag that fails to set or clear shows within three edges of the pin change, or on the first cycle after the return strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC = 6;
    localparam int IDXW = 3;
    localparam int NEXT = 2;
    localparam logic [7:0] ENABLE_WMASK = 8'hBF;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_LEVEL  = 2'd1,
        RA_SENSE  = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic            gate;
        logic            resv;
        logic [NSRC-1:0] src;
    } enable_t;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
    } pick_t;

    // lowest set index wins
    function automatic pick_t first_set(input logic [NSRC-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = IDXW'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [15:0] vec_of(input logic [IDXW-1:0] idx,
                                           input logic [15:0] base,
                                           input logic [15:0] step);
        return base + step * 16'(idx);
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             gate_o,
    output logic [NSRC-1:0]  src_en_o,
    output logic [NSRC-1:0]  level_o,
    output logic [NEXT-1:0]  sense_o
);

    enable_t         en_q;
    logic [NSRC-1:0] level_q;
    logic [NEXT-1:0] sense_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            level_q <= '0;
            sense_q <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                RA_ENABLE: en_q    <= enable_t'(wdata & ENABLE_WMASK);
                RA_LEVEL:  level_q <= wdata[NSRC-1:0];
                RA_SENSE:  sense_q <= wdata[NEXT-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_ENABLE: rdata = en_q;
            RA_LEVEL:  rdata = 8'(level_q);
            RA_SENSE:  rdata = 8'(sense_q);
            default:   rdata = '0;
        endcase
    end

    assign gate_o   = en_q.gate;
    assign src_en_o = en_q.src;
    assign level_o  = level_q;
    assign sense_o  = sense_q;

endmodule

// File: rtl/irq_ext_sense.sv
module irq_ext_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic trans_mode,
    input  logic clr,
    output logic req
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    logic                   pin_s;

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
            prev_q <= pin_s;
            if (!trans_mode)
                flag_q <= 1'b0;
            else if (prev_q && !pin_s)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign req = trans_mode ? flag_q : !pin_s;

    // R8: a latched transition survives until its acknowledge
    a_r8_flag_held: assert property (@(posedge clk) disable iff (rst)
        (trans_mode && flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter logic [15:0] VEC_BASE = 16'h0003,
    parameter logic [15:0] VEC_STEP = 16'h0008
) (
    input  logic [NSRC-1:0] src_req,
    input  logic            gate,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] level,
    input  logic            isr_hi,
    input  logic            isr_lo,
    output pick_t           sel,
    output logic            sel_hi,
    output logic            irq_req,
    output logic [15:0]     irq_vec
);

    logic [NSRC-1:0] elig;
    pick_t           hi_p;
    pick_t           lo_p;

    assign elig = gate ? (src_req & src_en) : '0;
    assign hi_p = first_set(elig & level);
    assign lo_p = first_set(elig & ~level);

    always_comb begin
        sel    = '0;
        sel_hi = 1'b0;
        if (!isr_hi) begin
            if (hi_p.valid) begin
                sel    = hi_p;
                sel_hi = 1'b1;
            end else if (!isr_lo) begin
                sel = lo_p;
            end
        end
    end

    assign irq_req = sel.valid;
    assign irq_vec = sel.valid ? vec_of(sel.idx, VEC_BASE, VEC_STEP) : 16'h0000;

endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
    import irq_pkg::*;
#(
    parameter logic [15:0] VEC_BASE    = 16'h0003,
    parameter logic [15:0] VEC_STEP    = 16'h0008,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [1:0]  ext_n,
    input  logic        tmr0_ovf,
    input  logic        tmr1_ovf,
    input  logic        ser_rx,
    input  logic        ser_tx,
    input  logic        tmr2_ovf,
    input  logic        tmr2_cap,
    input  logic        irq_ack,
    input  logic        irq_ret,
    output logic        irq_req,
    output logic [15:0] irq_vec
);

    localparam logic [15:0] VEC_LAST = VEC_BASE + VEC_STEP * 16'(NSRC - 1);

    logic            gate;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] level;
    logic [NEXT-1:0] sense;
    logic [NSRC-1:0] src_req;
    pick_t           sel;
    logic            sel_hi;
    logic            take;
    logic            isr_hi, isr_lo;
    logic            hi_n, lo_n;

    irq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .gate_o   (gate),
        .src_en_o (src_en),
        .level_o  (level),
        .sense_o  (sense)
    );

    // external pins sit at even source indices 0 and 2
    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        irq_ext_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk        (clk),
            .rst        (rst),
            .pin_n      (ext_n[k]),
            .trans_mode (sense[k]),
            .clr        (take && sel.idx == IDXW'(2 * k)),
            .req        (src_req[2 * k])
        );
    end

    assign src_req[1] = tmr0_ovf;
    assign src_req[3] = tmr1_ovf;
    assign src_req[4] = ser_rx | ser_tx;
    assign src_req[5] = tmr2_ovf | tmr2_cap;

    irq_arbiter #(.VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
        .src_req (src_req),
        .gate    (gate),
        .src_en  (src_en),
        .level   (level),
        .isr_hi  (isr_hi),
        .isr_lo  (isr_lo),
        .sel     (sel),
        .sel_hi  (sel_hi),
        .irq_req (irq_req),
        .irq_vec (irq_vec)
    );

    assign take = irq_ack && irq_req;

    // return closes the innermost level first, then an accepted vector opens its level
    always_comb begin
        hi_n = isr_hi;
        lo_n = isr_lo;
        if (irq_ret) begin
            if (isr_hi) hi_n = 1'b0;
            else        lo_n = 1'b0;
        end
        if (take) begin
            if (sel_hi) hi_n = 1'b1;
            else        lo_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_hi <= 1'b0;
            isr_lo <= 1'b0;
        end else begin
            isr_hi <= hi_n;
            isr_lo <= lo_n;
        end
    end

    a_r3_gate_closed: assert property (@(posedge clk) disable iff (rst)
        !gate |-> !irq_req);

    a_r5_vec_grid: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec >= VEC_BASE && irq_vec <= VEC_LAST &&
                     ((irq_vec - VEC_BASE) % VEC_STEP) == 16'h0000));

    a_r10_hi_blocks_all: assert property (@(posedge clk) disable iff (rst)
        isr_hi |-> !irq_req);

    a_r10_lo_only_preempt: assert property (@(posedge clk) disable iff (rst)
        (isr_lo && irq_req) |-> sel_hi);

    a_r11_ret_closes_hi: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && isr_hi) |=> !isr_hi);

    a_r12_stray_ack: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_req && !irq_ret) |=> ($stable(isr_hi) && $stable(isr_lo)));

endmodule

// File: tb/mcu_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mcu_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [1:0]  ext_n = 2'b11;
    logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, ser_rx = 1'b0, ser_tx = 1'b0;
    logic        tmr2_ovf = 1'b0, tmr2_cap = 1'b0;
    logic        irq_ack = 1'b0, irq_ret = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // bench-side mirror of the configuration and in-service levels
    logic [7:0] m_en = 8'd0;
    logic [5:0] m_lvl = 6'd0;
    logic       m_hi = 1'b0, m_lo = 1'b0;

    always #4 clk = ~clk;

    mcu_irq_ctrl u_mcu_irq_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_n(ext_n),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx),
        .tmr2_ovf(tmr2_ovf), .tmr2_cap(tmr2_cap), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    function automatic logic [15:0] vaddr(input int idx);
        return 16'h0003 + 16'(8 * idx);
    endfunction

    // returns {valid, high, index[2:0]}
    function automatic logic [4:0] model_pick(input logic [5:0] rq);
        logic [5:0] e;
        logic [4:0] r;
        r = '0;
        e = m_en[7] ? (rq & m_en[5:0]) : 6'd0;
        if (!m_hi) begin
            for (int i = 5; i >= 0; i--)
                if (e[i] && m_lvl[i]) r = {1'b1, 1'b1, 3'(i)};
            if (!r[4] && !m_lo)
                for (int i = 5; i >= 0; i--)
                    if (e[i] && !m_lvl[i]) r = {1'b1, 1'b0, 3'(i)};
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, 16'(reg_rdata), 16'(exp));
    endtask

    task automatic outchk(input string tag, input logic req, input logic [15:0] vec);
        settle();
        chk({tag, " req"}, 16'(irq_req), 16'(req));
        chk({tag, " vec"}, irq_vec, vec);
    endtask

    task automatic pulse_ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] t;
        logic [5:0]  rq;
        logic [4:0]  p;
        t = $urandom(32'h00C0FFEE);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        outchk("R1 reset", 1'b0, 16'h0000);
        rdchk("R1 enable", 2'd0, 8'h00);
        rdchk("R1 level", 2'd1, 8'h00);
        rdchk("R1 sense", 2'd2, 8'h00);

        // R2 layout and reserved bit
        wr(2'd0, 8'hFF); rdchk("R2 enable bit6", 2'd0, 8'hBF);
        wr(2'd1, 8'hFF); rdchk("R2 level", 2'd1, 8'h3F);
        wr(2'd2, 8'hFF); rdchk("R2 sense", 2'd2, 8'h03);
        rdchk("R2 unused addr", 2'd3, 8'h00);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // R3 global gate
        wr(2'd0, 8'h3F);
        tmr0_ovf = 1'b1;
        outchk("R3 gate closed", 1'b0, 16'h0000);
        wr(2'd0, 8'hBF);
        outchk("R3 gate open", 1'b1, vaddr(1));

        // R4 per-source enable
        wr(2'd0, 8'hBD);
        outchk("R4 timer0 disabled", 1'b0, 16'h0000);
        tmr0_ovf = 1'b0;

        // R6 merged request lines
        wr(2'd0, 8'h90);
        ser_tx = 1'b1;
        outchk("R6 serial tx", 1'b1, vaddr(4));
        ser_tx = 1'b0; ser_rx = 1'b1;
        outchk("R6 serial rx", 1'b1, vaddr(4));
        ser_rx = 1'b0;
        wr(2'd0, 8'hA0);
        tmr2_cap = 1'b1;
        outchk("R6 timer2 capture", 1'b1, vaddr(5));
        tmr2_cap = 1'b0;

        // R5 fixed order
        wr(2'd0, 8'hBF);
        tmr1_ovf = 1'b1; ser_rx = 1'b1; tmr2_ovf = 1'b1;
        outchk("R5 timer1 first", 1'b1, vaddr(3));
        tmr0_ovf = 1'b1;
        outchk("R5 timer0 first", 1'b1, vaddr(1));
        tmr1_ovf = 1'b0; ser_rx = 1'b0;

        // R9 high level beats order
        wr(2'd1, 8'h20);
        outchk("R9 timer2 high wins", 1'b1, vaddr(5));

        // R10 nesting, R11 return
        tmr2_ovf = 1'b0;
        outchk("R10 low presented", 1'b1, vaddr(1));
        pulse_ack();
        outchk("R10 low blocks low", 1'b0, 16'h0000);
        tmr2_ovf = 1'b1;
        outchk("R10 high preempts low", 1'b1, vaddr(5));
        pulse_ack();
        outchk("R10 high blocks all", 1'b0, 16'h0000);
        pulse_ret();
        outchk("R11 high closed first", 1'b1, vaddr(5));
        tmr2_ovf = 1'b0;
        outchk("R11 low still open", 1'b0, 16'h0000);
        pulse_ret();
        outchk("R11 low closed", 1'b1, vaddr(1));
        tmr0_ovf = 1'b0;

        // R12 stray acknowledge
        outchk("R12 idle", 1'b0, 16'h0000);
        pulse_ack();
        tmr1_ovf = 1'b1;
        outchk("R12 ack ignored", 1'b1, vaddr(3));
        tmr1_ovf = 1'b0;

        // R7 level sensing on external pin 0
        wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h85);
        @(negedge clk); ext_n[0] = 1'b0;
        outchk("R7 one edge", 1'b0, 16'h0000);
        outchk("R7 two edges", 1'b1, vaddr(0));
        ext_n[0] = 1'b1;
        settle();
        outchk("R7 not latched", 1'b0, 16'h0000);

        // R8 transition sensing on external pin 1
        wr(2'd2, 8'h02);
        @(negedge clk); ext_n[1] = 1'b0;
        settle(); settle();
        outchk("R8 edge latched", 1'b1, vaddr(2));
        ext_n[1] = 1'b1;
        settle(); settle(); settle();
        outchk("R8 held after pin high", 1'b1, vaddr(2));
        pulse_ack();
        pulse_ret();
        outchk("R8 cleared by ack", 1'b0, 16'h0000);

        // random phase on timer and serial sources
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_en = 8'd0; m_lvl = 6'd0; m_hi = 1'b0; m_lo = 1'b0;
        for (int it = 0; it < 4000; it++) begin
            @(negedge clk);
            t = $urandom;
            tmr0_ovf = t[0]; tmr1_ovf = t[1]; ser_rx = t[2]; ser_tx = t[3];
            tmr2_ovf = t[4]; tmr2_cap = t[5];
            irq_ack = (t[7:6] != 2'b00);
            irq_ret = (t[9:8] == 2'b00);
            reg_we = (t[12:10] == 3'b000);
            reg_addr = t[13] ? 2'd1 : 2'd0;
            reg_wdata = t[21:14];
            #1;
            rq = {tmr2_ovf | tmr2_cap, ser_rx | ser_tx, tmr1_ovf, 1'b0, tmr0_ovf, 1'b0};
            p = model_pick(rq);
            chk("R3/R4/R5/R9/R10 random req", 16'(irq_req), 16'(p[4]));
            chk("R5/R9 random vec", irq_vec, p[4] ? vaddr(int'(p[2:0])) : 16'h0000);
            if (irq_ret) begin
                if (m_hi) m_hi = 1'b0;
                else      m_lo = 1'b0;
            end
            if (irq_ack && p[4]) begin
                if (p[3]) m_hi = 1'b1;
                else      m_lo = 1'b1;
            end
            if (reg_we) begin
                if (reg_addr == 2'd0) m_en = reg_wdata & 8'hBF;
                else                  m_lvl = reg_wdata[5:0];
            end
        end
        @(negedge clk);
        irq_ack = 1'b0; irq_ret = 1'b0; reg_we = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule